// File: doc/BRIEF.md
# Keyboard and Display Console Register Block

This block places a byte-wide keyboard input and a byte-wide display output on a simple synchronous 32-bit processor bus. Software sees four word registers. For each device there is a control word and a data word. Each control word carries a ready flag and an interrupt-enable flag. The keyboard control word also carries a sticky overrun flag.

Software can poll the ready flag and then read a keyboard byte or write a display byte. It can instead set the enable flag and wait for the single interrupt line. The ready flags are never written directly. They change only as side effects: a keyboard byte arriving, the keyboard data word being read, the display data word being written, or the display side taking the byte.

The keyboard side is a one-cycle byte strobe. The display side presents a byte with a valid flag and holds it until an accept pulse arrives.

Top module: `mmio_console`

## Requirements
- R1: The registers sit at word addresses BASE+0x0 (keyboard control), BASE+0x4 (keyboard data), BASE+0x8 (display control) and BASE+0xC (display data), with BASE = 0xFFFF0000 by default. A read of any other address returns zero. A write to any other address changes no register.
- R2: In both control words, bit 0 is ready and is read-only, and bit 1 is the interrupt enable, which is written from wdata bit 1. All bits not defined read as zero.
- R3: A cycle with `kb_valid` high latches `kb_byte` into keyboard data and sets keyboard ready. The data word returns the byte in bits 7:0, with the upper bits zero.
- R4: A bus read of keyboard data clears keyboard ready at the next edge. If a byte arrives in the same cycle as that read, ready stays 1 and the new byte is kept.
- R5: A byte that arrives while keyboard ready is 1, and is not met by a read of keyboard data in the same cycle, sets the sticky overrun flag in keyboard control bit 2. Writing keyboard control with wdata bit 2 set clears it, and the clear wins over a set in the same cycle.
- R6: Display ready is 1 after reset. A write to display data latches wdata[7:0], clears display ready and raises `dsp_valid`. That word reads back the last byte written.
- R7: While `dsp_valid` is high, `dsp_byte` holds steady. An `dsp_accept` pulse with no display data write in the same cycle sets display ready and drops `dsp_valid` at the next edge. `dsp_accept` has no effect while display ready is 1.
- R8: `irq` is high exactly when (keyboard ready AND keyboard enable) OR (display ready AND display enable).
- R9: After reset, keyboard ready, overrun and both enables are 0, both data words are 0, and `irq` and `dsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the word access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; also triggers read side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, zero when not reading |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Keyboard byte |
| dsp_byte | output | 8 | Byte offered to the display |
| dsp_valid | output | 1 | Display byte pending |
| dsp_accept | input | 1 | Display has taken the byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these cycle collisions:
- A keyboard byte arriving in the same cycle as a read of keyboard data. A design that lets the clear win loses a character with no overrun recorded.
- An overrun set and an overrun clear in the same cycle. Getting the priority wrong leaves a stale or a missing overrun flag.
- A display write landing in the same cycle as an accept. A design that gives the accept priority marks the new byte as taken before it is shown.
- Writes of all ones to the control words. These must not set ready.
- Accesses just outside the four words. A loose address decode aliases onto a real register and corrupts it.

// File: rtl/mmio_console.sv
module mmio_console #(
  parameter logic [31:0] BASE = 32'hFFFF_0000,
  parameter int          CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          kb_valid,
  input  logic [CW-1:0] kb_byte,
  output logic [CW-1:0] dsp_byte,
  output logic          dsp_valid,
  input  logic          dsp_accept,
  output logic          irq
);
  localparam logic [31:0] A_KC = BASE;
  localparam logic [31:0] A_KD = BASE + 32'd4;
  localparam logic [31:0] A_DC = BASE + 32'd8;
  localparam logic [31:0] A_DD = BASE + 32'd12;

  logic          k_rdy, k_ie, k_ovr, d_rdy, d_ie;
  logic [CW-1:0] k_data, d_data;

  wire rd_kd = bus_re && bus_addr == A_KD;
  wire wr_kc = bus_we && bus_addr == A_KC;
  wire wr_dc = bus_we && bus_addr == A_DC;
  wire wr_dd = bus_we && bus_addr == A_DD;

  wire unused_wdata = ^bus_wdata[31:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_rdy  <= 1'b0;
      k_ie   <= 1'b0;
      k_ovr  <= 1'b0;
      k_data <= '0;
    end else begin
      if (kb_valid) begin
        k_data <= kb_byte;
        k_rdy  <= 1'b1;
        if (k_rdy && !rd_kd) k_ovr <= 1'b1;
      end else if (rd_kd) begin
        k_rdy <= 1'b0;
      end
      if (wr_kc) begin
        k_ie <= bus_wdata[1];
        if (bus_wdata[2]) k_ovr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_rdy  <= 1'b1;
      d_ie   <= 1'b0;
      d_data <= '0;
    end else begin
      if (wr_dd) begin
        d_data <= bus_wdata[CW-1:0];
        d_rdy  <= 1'b0;
      end else if (dsp_accept && !d_rdy) begin
        d_rdy <= 1'b1;
      end
      if (wr_dc) d_ie <= bus_wdata[1];
    end
  end

  assign dsp_valid = ~d_rdy;
  assign dsp_byte  = d_data;
  assign irq       = (k_rdy & k_ie) | (d_rdy & d_ie);

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_KC:    bus_rdata = {29'd0, k_ovr, k_ie, k_rdy};
        A_KD:    bus_rdata = {{(32-CW){1'b0}}, k_data};
        A_DC:    bus_rdata = {30'd0, d_ie, d_rdy};
        A_DD:    bus_rdata = {{(32-CW){1'b0}}, d_data};
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_kb_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> k_rdy && k_data == $past(kb_byte));

  assert_kb_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kd && !kb_valid |=> !k_rdy);

  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid && k_rdy && !rd_kd && !(wr_kc && bus_wdata[2]) |=> k_ovr);

  assert_dsp_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dd |=> dsp_valid && dsp_byte == $past(bus_wdata[CW-1:0]));

  assert_dsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && !dsp_accept && !wr_dd |=> dsp_valid && $stable(dsp_byte));

  assert_dsp_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && dsp_accept && !wr_dd |=> !dsp_valid);

  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == 32'd0);
endmodule

// File: tb/test_mmio_console.sv
module test_mmio_console;
  localparam logic [31:0] KC = 32'hFFFF_0000, KD = 32'hFFFF_0004,
                          DC = 32'hFFFF_0008, DD = 32'hFFFF_000C;
  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_we = 0, bus_re = 0, kb_valid = 0, dsp_accept = 0;
  logic [7:0] kb_byte = 0, dsp_byte;
  logic dsp_valid, irq;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int mkr, mkie, movr, mdr, mdie;
  logic [7:0] mkd, mdd;

  always #4 clk = ~clk;

  mmio_console i_mmio_console (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid),
    .kb_byte(kb_byte), .dsp_byte(dsp_byte), .dsp_valid(dsp_valid), .dsp_accept(dsp_accept), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    case (a)
      KC: return {29'd0, movr[0], mkie[0], mkr[0]};
      KD: return {24'd0, mkd};
      DC: return {30'd0, mdie[0], mdr[0]};
      DD: return {24'd0, mdd};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    case (a)
      KC: return "R2";
      KD: return "R3";
      DC: return "R6";
      DD: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input bit we, input bit re, input logic [31:0] a, input logic [31:0] wd,
                      input bit kv, input logic [7:0] kb, input bit acc, input string tag);
    bit rd;
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
    kb_valid = kv; kb_byte = kb; dsp_accept = acc;
    #1;
    if (re) check(bus_rdata, exp_rd(a), tag);
    @(posedge clk);
    rd = re && a == KD;
    if (kv) begin
      if (mkr != 0 && !rd) movr = 1;
      mkd = kb; mkr = 1;
    end else if (rd) mkr = 0;
    if (we && a == KC) begin mkie = wd[1]; if (wd[2]) movr = 0; end
    if (we && a == DD) begin mdd = wd[7:0]; mdr = 0; end
    else if (acc && mdr == 0) mdr = 1;
    if (we && a == DC) mdie = wd[1];
    #2;
    check(irq, ((mkr & mkie) | (mdr & mdie)) != 0, "R8");
    check(dsp_valid, mdr == 0, "R6");
    if (dsp_valid) check(dsp_byte, mdd, "R7");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    mkr = 0; mkie = 0; movr = 0; mdr = 1; mdie = 0; mkd = 0; mdd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(irq, 0, "R9");
    check(dsp_valid, 0, "R9");
    rst_n = 1;
    step(0, 1, KC, 0, 0, 0, 0, "R9");
    step(0, 1, DC, 0, 0, 0, 0, "R9");
    step(0, 1, KD, 0, 0, 0, 0, "R9");
    // R3 latch, R4 clear on read
    step(0, 0, 0, 0, 1, 8'h5A, 0, "R3");
    step(0, 1, KC, 0, 0, 0, 0, "R3");
    step(0, 1, KD, 0, 0, 0, 0, "R3");
    step(0, 1, KC, 0, 0, 0, 0, "R4");
    // R4 read colliding with a new byte keeps ready set
    step(0, 0, 0, 0, 1, 8'h11, 0, "R4");
    step(0, 1, KD, 0, 1, 8'h22, 0, "R4");
    step(0, 1, KC, 0, 0, 0, 0, "R4");
    step(0, 1, KD, 0, 0, 0, 0, "R4");
    // R5 overrun, then set and clear in one cycle
    step(0, 0, 0, 0, 1, 8'h33, 0, "R5");
    step(0, 0, 0, 0, 1, 8'h44, 0, "R5");
    step(0, 1, KC, 0, 0, 0, 0, "R5");
    step(1, 0, KC, 32'h4, 1, 8'h55, 0, "R5");
    step(0, 1, KC, 0, 0, 0, 0, "R5");
    // R2 ready is read-only, undefined bits read zero
    step(0, 1, KD, 0, 0, 0, 0, "R2");
    step(1, 0, KC, 32'hFFFF_FFFF, 0, 0, 0, "R2");
    step(0, 1, KC, 0, 0, 0, 0, "R2");
    step(1, 0, DC, 32'hFFFF_FFFE, 0, 0, 0, "R2");
    step(0, 1, DC, 0, 0, 0, 0, "R2");
    // R8 keyboard interrupt
    step(0, 0, 0, 0, 1, 8'h66, 0, "R8");
    step(0, 1, KD, 0, 0, 0, 0, "R8");
    // R1 addresses just outside the map
    step(1, 0, 32'hFFFF_0010, 32'hFFFF_FFFF, 0, 0, 0, "R1");
    step(1, 0, 32'hFFFE_0000, 32'h0000_0000, 0, 0, 0, "R1");
    step(1, 0, 32'hFFFF_0002, 32'h0000_0000, 0, 0, 0, "R1");
    step(0, 1, 32'hFFFF_0010, 0, 0, 0, 0, "R1");
    step(0, 1, 32'h0000_0004, 0, 0, 0, 0, "R1");
    step(0, 1, KC, 0, 0, 0, 0, "R1");
    step(0, 1, DC, 0, 0, 0, 0, "R1");
    // R6 and R7 display handshake
    step(1, 0, DD, 32'hABCD_12A5, 0, 0, 0, "R6");
    step(0, 1, DC, 0, 0, 0, 0, "R6");
    step(0, 1, DD, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, DD, 32'h3C, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(0, 1, DC, 0, 0, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      int s;
      s = $urandom_range(0, 6);
      case (s)
        0: a = KC; 1: a = KD; 2: a = DC; 3: a = DD;
        4: a = 32'hFFFF_0014; 5: a = 32'h7FFF_0000; default: a = KD;
      endcase
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, a, $urandom,
           $urandom_range(0, 4) == 0, 8'($urandom), $urandom_range(0, 2) == 0, tag_of(a));
    end
    finish_run();
  end
endmodule